// File: doc/BRIEF.md
# Push-Button Conditioner With Press Pulse

This block cleans up one mechanical push-button signal. The raw pin first passes through a synchroniser, which brings it into the clock domain. A lockout debouncer then takes the first change it sees straight to its output. After that change it blanks every further input movement for a programmable interval, so contact bounce cannot reach the output. The interval is given in milliseconds together with the clock rate and is converted to clock cycles.

The clean level drives a rising-edge detector. The detector produces a press strobe that is high for exactly one clock cycle on each accepted press. When the sticky option is built in, the strobe sets a run flag that stays high until reset. Downstream logic can use the strobe to advance a circuit by one step, and the flag to start it running for good.

Top module: `btn_conditioner`

## Requirements
- R1: With the lockout idle, a change on `btn_raw_i` driven just after a clock edge appears on `level_o` after the third following rising clock edge (two synchroniser stages plus the level register).
- R2: The first change reaching the debouncer while no lockout is running is accepted at once, even if the raw input held the new value for a single clock cycle.
- R3: After every change of `level_o`, the level holds for at least LOCK_CYCLES+1 clock cycles (LOCK_CYCLES = CLK_HZ/1000 × LOCK_MS). Raw changes during that window are ignored, so a bouncing press gives one rise and a bouncing release gives one fall.
- R4: When the lockout ends and the synchronised input differs from `level_o`, the level follows on the next edge. A one-cycle glitch from idle therefore yields a level high for exactly LOCK_CYCLES+1 cycles.
- R5: `press_pulse_o` is high for exactly one clock cycle: the cycle after `level_o` goes from 0 to 1. There is exactly one pulse per accepted rise.
- R6: A falling `level_o` produces no pulse.
- R7: With STICKY_EN=1, `run_flag_o` goes to 1 on the clock edge that ends a pulse and stays 1 until reset.
- R8: With STICKY_EN=0, `run_flag_o` stays 0 at all times while pulses still appear.
- R9: A clock edge with `rst_ni` low clears the synchroniser, the level, the edge history, the lockout counter and the run flag. All three outputs read 0 after it. After release, a raw input that is already high is treated as a new press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| btn_raw_i | input | 1 | Raw, asynchronous button level |
| level_o | output | 1 | Debounced button level |
| press_pulse_o | output | 1 | One-cycle strobe per accepted press |
| run_flag_o | output | 1 | Sticky run flag (0 when STICKY_EN=0) |

## Verification
The bench drives bouncing presses and releases and counts the level changes and pulses. A debouncer that re-armed too early or filtered too late would show extra toggles or a second pulse per press. A lone one-cycle glitch is also applied; the bench measures both the three-cycle acceptance latency and the exact LOCK_CYCLES+1 hold, so an off-by-one in the counter shows up as a wrong count. Reset is asserted in the middle of a held press to prove that every state element clears and that a still-held button is seen as a fresh press. A second instance built without the sticky option must pulse identically and never raise its flag.

// File: rtl/btn_pkg.sv
// Shared helpers for the push-button conditioner.
// Assumes clock rates that are a whole multiple of 1 kHz.
package btn_pkg;

    // Shortest synchroniser that still tolerates metastability.
    localparam int unsigned SYNC_MIN_STAGES = 2;

    // Convert a lockout in milliseconds into clock cycles (at least one).
    function automatic int unsigned lockout_cycles(int unsigned clk_hz, int unsigned ms);
        int unsigned c;
        c = (clk_hz / 1000) * ms;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/btn_sync.sv
// Synchroniser: shifts an asynchronous level through STAGES flops.
// Assumes STAGES >= 2; output lags the input by STAGES edges.
module btn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the raw level one stage per clock; reset clears all stages.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain <= '0;
        else         chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/btn_lockout.sv
// Lockout debouncer: takes the first change at once, then ignores the
// input for LOCK_CYCLES further edges. Assumes a synchronised input.
module btn_lockout #(
    parameter int unsigned LOCK_CYCLES = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic level_o
);
    localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);

    logic [CW-1:0] remain;
    logic          level;

    // Accept a change only when no lockout runs; otherwise count it down.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            level  <= 1'b0;
            remain <= '0;
        end else if (remain == '0) begin
            if (din_i != level) begin
                level  <= din_i;
                remain <= CW'(LOCK_CYCLES);
            end
        end else begin
            remain <= remain - CW'(1);
        end
    end

    assign level_o = level;
endmodule

// File: rtl/btn_rise_pulse.sv
// Rising-edge detector: one-cycle strobe when the level goes 0 -> 1.
// Assumes the level input is already registered in this clock domain.
module btn_rise_pulse (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic pulse_o
);
    logic prev;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev <= 1'b0;
        else         prev <= level_i;
    end

    assign pulse_o = level_i & ~prev;
endmodule

// File: rtl/btn_run_latch.sv
// Run flag: set by the press strobe, held until reset. With STICKY_EN=0
// the flag is tied low. Assumes the strobe lasts one cycle.
module btn_run_latch #(
    parameter bit STICKY_EN = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pulse_i,
    output logic run_o
);
    if (STICKY_EN) begin : g_sticky
        logic run;

        // Set on any strobe, clear only through reset.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)      run <= 1'b0;
            else if (pulse_i) run <= 1'b1;
        end

        assign run_o = run;
    end else begin : g_none
        logic unused_inputs;
        assign unused_inputs = &{1'b0, clk_i, rst_ni, pulse_i};
        assign run_o         = 1'b0;
    end
endmodule

// File: rtl/btn_conditioner.sv
// Push-button conditioner: synchroniser -> lockout debouncer ->
// rising-edge strobe -> optional sticky run flag.
// Assumes one clock domain and a synchronous active-low reset.
module btn_conditioner #(
    parameter int unsigned CLK_HZ      = 125_000_000,
    parameter int unsigned LOCK_MS     = 10,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          STICKY_EN   = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic btn_raw_i,
    output logic level_o,
    output logic press_pulse_o,
    output logic run_flag_o
);
    localparam int unsigned LOCK_CYCLES = btn_pkg::lockout_cycles(CLK_HZ, LOCK_MS);
    localparam int unsigned STAGES_USED =
        (SYNC_STAGES < btn_pkg::SYNC_MIN_STAGES) ? btn_pkg::SYNC_MIN_STAGES : SYNC_STAGES;

    logic sync_q;
    logic level;
    logic pulse;
    logic run;

    btn_sync #(.STAGES(STAGES_USED)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(btn_raw_i), .q_o(sync_q)
    );

    btn_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lockout (
        .clk_i(clk_i), .rst_ni(rst_ni), .din_i(sync_q), .level_o(level)
    );

    btn_rise_pulse u_rise (
        .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level), .pulse_o(pulse)
    );

    btn_run_latch #(.STICKY_EN(STICKY_EN)) u_run (
        .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(pulse), .run_o(run)
    );

    assign level_o       = level;
    assign press_pulse_o = pulse;
    assign run_flag_o    = run;
endmodule

// File: rtl/btn_conditioner_chk.sv
// Checker for btn_conditioner, bound to every instance below.
// Tracks cycles since the last level change to check the lockout window.
module btn_conditioner_chk #(
    parameter int unsigned LOCK_CYCLES = 8,
    parameter bit          STICKY_EN   = 1'b1
) (
    input logic clk_i,
    input logic rst_ni,
    input logic level_o,
    input logic press_pulse_o,
    input logic run_flag_o
);
    localparam int unsigned SW = $clog2(LOCK_CYCLES + 2);

    logic          level_q;
    logic          armed;
    logic [SW-1:0] since;

    // Count cycles since the last observed level change, saturating.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            level_q <= 1'b0;
            armed   <= 1'b0;
            since   <= '0;
        end else begin
            level_q <= level_o;
            if (level_o != level_q) begin
                armed <= 1'b1;
                since <= '0;
            end else if (since != SW'(LOCK_CYCLES)) begin
                since <= since + SW'(1);
            end
        end
    end

    // R3
    lockout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && (level_o != level_q)) |-> (since >= SW'(LOCK_CYCLES)));

    // R5
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        press_pulse_o |=> !press_pulse_o);

    // R5
    pulse_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(level_o) |-> press_pulse_o);

    // R6
    pulse_only_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        press_pulse_o |-> (level_o && !$past(level_o)));

    // R9
    reset_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!level_o && !press_pulse_o && !run_flag_o));

    if (STICKY_EN) begin : g_sticky_chk
        // R7
        run_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            press_pulse_o |=> run_flag_o);
        // R7
        run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            run_flag_o |=> run_flag_o);
    end else begin : g_plain_chk
        // R8
        run_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !run_flag_o);
    end
endmodule

bind btn_conditioner btn_conditioner_chk #(
    .LOCK_CYCLES(LOCK_CYCLES),
    .STICKY_EN  (STICKY_EN)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .level_o      (level_o),
    .press_pulse_o(press_pulse_o),
    .run_flag_o   (run_flag_o)
);

// File: tb/btn_conditioner_bench.sv
module btn_conditioner_bench;
    localparam int unsigned LOCK = 8;  // 1000 Hz x 8 ms

    typedef struct packed {
        logic       raw;
        logic [7:0] cycles;
        logic       chk;
        logic       lvl;
        logic       run;
        logic [3:0] pulses;   // cumulative
        logic [3:0] toggles;  // cumulative
    } vec_t;

    // Bouncing press, bouncing release, clean press, one-cycle glitch.
    localparam vec_t VECS [0:14] = '{
        '{1'b0, 8'd20, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b1, 8'd2,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b0, 8'd1,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b1, 8'd1,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b0, 8'd2,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b1, 8'd30, 1'b1, 1'b1, 1'b1, 4'd1, 4'd1},
        '{1'b0, 8'd1,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b1, 8'd2,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b0, 8'd1,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b1, 8'd1,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b0, 8'd30, 1'b1, 1'b0, 1'b1, 4'd1, 4'd2},
        '{1'b1, 8'd20, 1'b1, 1'b1, 1'b1, 4'd2, 4'd3},
        '{1'b0, 8'd20, 1'b1, 1'b0, 1'b1, 4'd2, 4'd4},
        '{1'b1, 8'd1,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b0, 8'd30, 1'b1, 1'b0, 1'b1, 4'd3, 4'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw = 1'b0;
    logic lvl, pulse, run;
    logic p_lvl, p_pulse, p_run;

    int tests = 0, fails = 0;
    int pulse_total = 0, toggle_total = 0, plain_pulse_total = 0;
    logic prev_lvl = 1'b0;

    always #4 clk = ~clk;

    btn_conditioner #(.CLK_HZ(1000), .LOCK_MS(LOCK), .STICKY_EN(1'b1)) u_btn_conditioner (
        .clk_i(clk), .rst_ni(rst_n), .btn_raw_i(raw),
        .level_o(lvl), .press_pulse_o(pulse), .run_flag_o(run)
    );

    btn_conditioner #(.CLK_HZ(1000), .LOCK_MS(LOCK), .STICKY_EN(1'b0)) u_btn_conditioner_plain (
        .clk_i(clk), .rst_ni(rst_n), .btn_raw_i(raw),
        .level_o(p_lvl), .press_pulse_o(p_pulse), .run_flag_o(p_run)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance one clock, sample just after the edge and update counters.
    task automatic tick();
        @(posedge clk);
        #1;
        if (pulse)   pulse_total++;
        if (p_pulse) plain_pulse_total++;
        if (lvl != prev_lvl) toggle_total++;
        prev_lvl = lvl;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        int base;
        // Reset state (R9)
        repeat (3) tick();
        check(lvl == 0 && pulse == 0 && run == 0, "R9", "outputs in reset",
              {lvl, pulse, run}, 0);
        rst_n = 1'b1;

        // Table walk (R2 R3 R4 R5 R6 R7 R8)
        for (int i = 0; i <= 14; i++) begin
            raw = VECS[i].raw;
            for (int k = 0; k < int'(VECS[i].cycles); k++) tick();
            if (VECS[i].chk) begin
                check(lvl == VECS[i].lvl, "R3", $sformatf("row %0d level", i),
                      lvl, VECS[i].lvl);
                check(toggle_total == int'(VECS[i].toggles), "R3",
                      $sformatf("row %0d level changes", i), toggle_total, VECS[i].toggles);
                check(pulse_total == int'(VECS[i].pulses), "R5",
                      $sformatf("row %0d pulses", i), pulse_total, VECS[i].pulses);
                check(run == VECS[i].run, "R7", $sformatf("row %0d run flag", i),
                      run, VECS[i].run);
                check(plain_pulse_total == pulse_total, "R8",
                      $sformatf("row %0d plain pulses", i), plain_pulse_total, pulse_total);
                check(p_run == 1'b0, "R8", $sformatf("row %0d plain run", i), p_run, 0);
            end
        end

        // Acceptance latency and exact glitch hold (R1 R2 R4)
        raw = 1'b1;
        n = 0;
        while (!lvl && n < 20) begin
            tick();
            n++;
        end
        check(n == 3, "R1", "cycles from raw to level", n, 3);
        raw = 1'b0;
        n = 1;
        while (lvl && n < 40) begin
            tick();
            if (lvl) n++;
        end
        check(n == int'(LOCK) + 1, "R4", "glitch level high cycles", n, LOCK + 1);
        check(pulse_total == 4, "R2", "glitch accepted as press", pulse_total, 4);

        // Reset in the middle of a held press (R9 R7)
        raw = 1'b1;
        repeat (15) tick();
        check(pulse_total == 5 && lvl == 1, "R5", "held press pulses", pulse_total, 5);
        base = pulse_total;
        rst_n = 1'b0;
        tick();
        check(lvl == 0 && run == 0 && pulse == 0, "R9", "cleared mid press",
              {lvl, run, pulse}, 0);
        tick();
        check(pulse_total == base, "R9", "no pulse in reset", pulse_total, base);
        rst_n = 1'b1;
        n = 0;
        while (!lvl && n < 20) begin
            tick();
            n++;
        end
        check(n == 3, "R9", "held button seen after reset", n, 3);
        check(pulse == 1, "R5", "pulse after reset", pulse, 1);
        check(run == 0, "R7", "run before set edge", run, 0);
        tick();
        check(run == 1 && pulse == 0, "R7", "run set, pulse gone", {run, pulse}, 2);

        // Release gives no pulse (R6)
        base = pulse_total;
        raw = 1'b0;
        repeat (25) tick();
        check(lvl == 0, "R6", "level after release", lvl, 0);
        check(pulse_total == base, "R6", "no pulse on fall", pulse_total, base);
        check(run == 1, "R7", "run holds after release", run, 1);
        check(p_run == 0 && plain_pulse_total == pulse_total, "R8", "plain variant",
              p_run, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule